// File: doc/BRIEF.md
# Stack Pop Sequencer

This block carries out a multi-register pop that has already been decoded. A caller gives it a 16-bit selection mask and the current stack pointer, then pulses `start`. The block checks that the stack pointer is word aligned. It writes the final stack pointer value once, before any memory traffic. It then fetches one 32-bit word per selected register. The fetches start at the old stack pointer and run upward in 4-byte steps. Each fetched word goes out on a register write port, in ascending register-number order.

The word for register 15, the program counter, goes out on a separate program-counter load port instead. When that happens, a branch indication accompanies completion. A memory read error stops the sequence at once. Completion is then flagged with an error. A misaligned stack pointer is refused before any write or read takes place. Only one memory read is in flight at a time, and completion is a single-cycle `done` pulse.

Top module: `stack_pop_seq`

## Requirements
- R1: The first read address equals the stack pointer given at start. Each later read is 4 above the previous one. The k-th returned word (k counted from 0) is delivered with the k-th selected register.
- R2: Registers are written in ascending index order. Each set mask bit consumes exactly one word, and each index 0..14 is written at most once, through `rf_we`/`rf_idx`/`rf_wdata`.
- R3: In the cycle after `start` is accepted, `sp_we` pulses once with old SP + 4 × (number of set mask bits). This is strictly before the first `mem_req`.
- R4: Address and stack-pointer arithmetic wraps modulo 2^32.
- R5: The word for mask bit 15 appears on `pc_we`/`pc_wdata`, never on `rf_we`. `branch` is high together with `done` when that word was loaded and no error occurred.
- R6: Every `mem_addr` presented with `mem_req` has its two low bits at zero.
- R7: A response with `mem_err` high ends the sequence. The next cycle has `done` and `err` high and `branch` low, and no register or PC write follows the error.
- R8: If `sp_in[1:0]` is not zero at start, `done` and `err` rise in the cycle after start. There is no `sp_we` and no `mem_req`.
- R9: `mem_req` is a one-cycle pulse with at most one read outstanding. The next request comes in the cycle after a response is accepted. A sequence of n reads ends with `done` 2 + n × (2 + L) cycles after start, where L is the memory's response delay in cycles.
- R10: `done` lasts one cycle. `start` is ignored while `busy` is high: it neither changes the running sequence nor causes a second completion. After reset, `busy`, `done`, `mem_req`, `sp_we`, `rf_we` and `pc_we` are low.
- R11: An all-zero mask writes SP unchanged, issues no read, and completes 2 cycles after start without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pop (taken only when idle) |
| reg_mask | input | 16 | Registers to load, bit i selects register i |
| sp_in | input | 32 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion with error (valid with done) |
| branch | output | 1 | PC was loaded (valid with done) |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Word-aligned read address |
| mem_valid | input | 1 | Read response present |
| mem_rdata | input | 32 | Read response data |
| mem_err | input | 1 | Read response is a fault |
| rf_we | output | 1 | Register file write enable |
| rf_idx | output | 4 | Register index written |
| rf_wdata | output | 32 | Register write data |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | 32 | New stack pointer value |
| pc_we | output | 1 | Program counter load enable |
| pc_wdata | output | 32 | Program counter load value |

## Verification
Counted from the edge that takes `start`, the stack pointer write is due one cycle later. The first request follows one cycle after that. Each register write appears in the same cycle as the accepted response. `done` follows 2 + n × (2 + L) cycles after start, 1 cycle for a misaligned pointer, and 2 for an empty mask. The bench drives inputs and samples outputs on the falling edge. A monitor checks every request, SP write and register write in the cycle it appears, against addresses and data the bench computes from the mask and the starting pointer. The run task counts falling edges from start to `done` and compares the count with that formula.

// File: rtl/stack_pop_pkg.sv
package stack_pop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SPW  = 3'd1,
    ST_REQ  = 3'd2,
    ST_WAIT = 3'd3,
    ST_FIN  = 3'd4
  } pop_state_e;

  localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/stack_pop_pick.sv
module stack_pop_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          found
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  generate
    for (genvar g = 0; g < N; g++) begin : g_chain
      assign onehot[g]  = mask[g] & ~seen[g];
      assign seen[g+1]  = seen[g] | mask[g];
    end
  endgenerate

  assign found = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end

  // R2: the chain must never select more than one register at a time
  always_comb begin
    a_r2_single_pick: assert ($onehot0(onehot));
  end

endmodule

// File: rtl/stack_pop_addr.sv
module stack_pop_addr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);

  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + AW'(STEP);
  endfunction

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (step) addr_q <= next_word(addr_q);
  end

  assign addr = addr_q;

  // R1 / R4: a step moves the pointer by one word, wrapping at the top
  a_r1_step_word: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr == $past(addr) + AW'(STEP)));

endmodule

// File: rtl/stack_pop_seq.sv
module stack_pop_seq
  import stack_pop_pkg::*;
#(
  parameter int NREGS  = 16,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int PC_IDX = NREGS - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NREGS-1:0]         reg_mask,
  input  logic [AW-1:0]            sp_in,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic                     branch,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  input  logic                     mem_valid,
  input  logic [DW-1:0]            mem_rdata,
  input  logic                     mem_err,
  output logic                     rf_we,
  output logic [$clog2(NREGS)-1:0] rf_idx,
  output logic [DW-1:0]            rf_wdata,
  output logic                     sp_we,
  output logic [AW-1:0]            sp_wdata,
  output logic                     pc_we,
  output logic [DW-1:0]            pc_wdata
);

  localparam int IW = $clog2(NREGS);
  localparam int CW = $clog2(NREGS + 1);

  // ---------------------------------------------------------------- arithmetic
  function automatic logic [CW-1:0] count_sel(input logic [NREGS-1:0] m);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < NREGS; i++) n = n + CW'(m[i]);
    return n;
  endfunction

  function automatic logic [AW-1:0] sp_final(input logic [AW-1:0] b,
                                             input logic [CW-1:0] n);
    return b + (AW'(n) * AW'(WORD_BYTES));
  endfunction

  function automatic logic misaligned(input logic [AW-1:0] a);
    return |a[1:0];
  endfunction

  // ---------------------------------------------------------------- state
  pop_state_e       state_q;
  logic [NREGS-1:0] mask_q;
  logic [AW-1:0]    base_q;
  logic             err_q;
  logic             pc_hit_q;
  logic             first_req_q;
  logic [AW-1:0]    last_req_q;

  // ---------------------------------------------------------------- events
  logic             start_ok;
  logic             bad_sp;
  logic             accept;
  logic             read_fail;
  logic             word_ok;
  logic             is_pc;
  logic             list_empty;
  logic [NREGS-1:0] rest_mask;
  logic             last_word;

  logic [NREGS-1:0] pick_onehot;
  logic [IW-1:0]    pick_idx;
  logic             pick_found;
  logic [AW-1:0]    cur_addr;

  stack_pop_pick #(.N(NREGS), .IW(IW)) u_pick (
    .mask   (mask_q),
    .onehot (pick_onehot),
    .idx    (pick_idx),
    .found  (pick_found)
  );

  stack_pop_addr #(.AW(AW), .STEP(WORD_BYTES)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .load_val (sp_in),
    .step     (word_ok),
    .addr     (cur_addr)
  );

  assign start_ok   = start && (state_q == ST_IDLE);
  assign bad_sp     = misaligned(sp_in);
  assign accept     = (state_q == ST_WAIT) && mem_valid;
  assign read_fail  = accept && mem_err;
  assign word_ok    = accept && !mem_err;
  assign is_pc      = (pick_idx == IW'(PC_IDX));
  assign list_empty = (mask_q == '0);
  assign rest_mask  = mask_q & ~pick_onehot;
  assign last_word  = word_ok && (rest_mask == '0);

  // ---------------------------------------------------------------- sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      base_q   <= '0;
      err_q    <= 1'b0;
      pc_hit_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            mask_q   <= reg_mask;
            base_q   <= sp_in;
            pc_hit_q <= 1'b0;
            err_q    <= bad_sp;
            state_q  <= bad_sp ? ST_FIN : ST_SPW;
          end
        end
        ST_SPW:  state_q <= list_empty ? ST_FIN : ST_REQ;
        ST_REQ:  state_q <= ST_WAIT;
        ST_WAIT: begin
          if (read_fail) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else if (word_ok) begin
            mask_q <= rest_mask;
            if (is_pc) pc_hit_q <= 1'b1;
            state_q <= last_word ? ST_FIN : ST_REQ;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // tracking for the ordering checks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_req_q <= 1'b0;
      last_req_q  <= '0;
    end else begin
      if (state_q == ST_SPW)  first_req_q <= 1'b1;
      else if (mem_req)       first_req_q <= 1'b0;
      if (mem_req)            last_req_q  <= mem_addr;
    end
  end

  // ---------------------------------------------------------------- outputs
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FIN);
  assign err      = done && err_q;
  assign branch   = done && pc_hit_q && !err_q;

  assign mem_req  = (state_q == ST_REQ);
  assign mem_addr = cur_addr;

  assign sp_we    = (state_q == ST_SPW);
  assign sp_wdata = sp_final(base_q, count_sel(mask_q));

  assign rf_we    = word_ok && !is_pc;
  assign rf_idx   = pick_idx;
  assign rf_wdata = mem_rdata;
  assign pc_we    = word_ok && is_pc;
  assign pc_wdata = mem_rdata;

  // ---------------------------------------------------------------- assertions
  // R3: the first read is preceded by the stack pointer write
  a_r3_sp_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && first_req_q) |-> $past(sp_we));

  // R1: each later request is one word above the one before it
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !first_req_q) |-> (mem_addr == last_req_q + AW'(WORD_BYTES)));

  // R6: only word-aligned reads are issued
  a_r6_aligned_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R9: a request never lasts two cycles
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R7: a faulting response leads straight to an erroring completion
  a_r7_abort_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    read_fail |=> (done && err && !rf_we && !pc_we));

  // R8: a misaligned pointer completes next cycle with an error
  a_r8_bad_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && bad_sp) |=> (done && err && !sp_we));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: branch only with a clean completion
  a_r5_branch_clean: assert property (@(posedge clk) disable iff (!rst_n)
    branch |-> (done && !err));

  // R2: a register write always comes from a selected register
  a_r2_write_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || pc_we) |-> pick_found);

endmodule

// File: tb/test_stack_pop_seq.sv
module test_stack_pop_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reg_mask = '0;
  logic [31:0] sp_in = '0;
  logic        busy, done, err, branch;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_rdata;
  logic        mem_err;
  logic        rf_we;
  logic [3:0]  rf_idx;
  logic [31:0] rf_wdata;
  logic        sp_we;
  logic [31:0] sp_wdata;
  logic        pc_we;
  logic [31:0] pc_wdata;

  always #4 clk = ~clk;

  stack_pop_seq i_stack_pop_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_mask(reg_mask), .sp_in(sp_in),
    .busy(busy), .done(done), .err(err), .branch(branch),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .mem_err(mem_err),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[31:16]};
  endfunction

  function automatic int nth_set(input logic [15:0] m, input int k);
    int c = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (c == k) return i;
        c++;
      end
    end
    return -1;
  endfunction

  function automatic int pop16(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  // ---------------------------------------------------------------- memory model
  int          cur_lat  = 0;
  int          cur_errn = 0;
  logic        clr = 1'b0;
  logic        pend = 1'b0;
  int          pcnt = 0;
  logic [31:0] paddr = '0;
  logic        pfail = 1'b0;
  int          mreq_cnt = 0;

  always @(posedge clk) begin
    if (clr) begin
      mreq_cnt <= 0;
      pend     <= 1'b0;
    end else if (mem_req) begin
      pend     <= 1'b1;
      pcnt     <= cur_lat;
      paddr    <= mem_addr;
      pfail    <= (mreq_cnt + 1 == cur_errn);
      mreq_cnt <= mreq_cnt + 1;
    end else if (mem_valid) begin
      pend <= 1'b0;
    end else if (pend && pcnt != 0) begin
      pcnt <= pcnt - 1;
    end
  end

  assign mem_valid = pend && (pcnt == 0);
  assign mem_rdata = mem_valid ? mem_word(paddr) : 32'h0;
  assign mem_err   = mem_valid && pfail;

  // ---------------------------------------------------------------- monitor
  logic        active = 1'b0;
  logic [15:0] cur_mask = '0;
  logic [31:0] cur_sp = '0;
  int          nreq = 0, nwr = 0, nsp = 0;
  logic        prev_req = 1'b0;

  always @(negedge clk) begin
    if (active) begin
      if (mem_req) begin
        chk(mem_addr == cur_sp + 32'(4 * nreq), "R1/R4 read address", mem_addr,
            cur_sp + 32'(4 * nreq));
        chk(mem_addr[1:0] == 2'b00, "R6 alignment", mem_addr, {mem_addr[31:2], 2'b00});
        chk(nsp == 1, "R3 SP written before read", 32'(nsp), 32'd1);
        chk(!prev_req, "R9 one outstanding", 32'(prev_req), 32'd0);
        nreq++;
      end
      if (sp_we) begin
        chk(sp_wdata == cur_sp + 32'(4 * pop16(cur_mask)), "R3 SP value", sp_wdata,
            cur_sp + 32'(4 * pop16(cur_mask)));
        nsp++;
      end
      if (rf_we || pc_we) begin
        if (rf_we) begin
          chk(int'(rf_idx) == nth_set(cur_mask, nwr) && rf_idx != 4'd15,
              "R2 ascending index", 32'(rf_idx), 32'(nth_set(cur_mask, nwr)));
          chk(rf_wdata == mem_word(cur_sp + 32'(4 * nwr)), "R1 register data", rf_wdata,
              mem_word(cur_sp + 32'(4 * nwr)));
        end
        if (pc_we) begin
          chk(nth_set(cur_mask, nwr) == 15 && !rf_we, "R5 PC port", 32'(nth_set(cur_mask, nwr)),
              32'd15);
          chk(pc_wdata == mem_word(cur_sp + 32'(4 * nwr)), "R5 PC data", pc_wdata,
              mem_word(cur_sp + 32'(4 * nwr)));
        end
        nwr++;
      end
      prev_req <= mem_req;
    end else begin
      prev_req <= 1'b0;
    end
  end

  // ---------------------------------------------------------------- run task
  task automatic run(input logic [15:0] m, input logic [31:0] s, input int lat,
                     input int errn, input bit poke);
    int  n, reads, writes, cyc, exp_cyc;
    bit  aligned, exp_err, exp_br;
    n       = pop16(m);
    aligned = (s[1:0] == 2'b00);
    exp_err = !aligned || (errn != 0 && errn <= n);
    reads   = !aligned ? 0 : ((errn != 0 && errn <= n) ? errn : n);
    writes  = !aligned ? 0 : ((errn != 0 && errn <= n) ? errn - 1 : n);
    exp_br  = m[15] && !exp_err;
    exp_cyc = aligned ? 2 + reads * (2 + lat) : 1;

    cur_lat = lat; cur_errn = errn; cur_mask = m; cur_sp = s;
    nreq = 0; nwr = 0; nsp = 0;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    start = 1'b1; reg_mask = m; sp_in = s; active = 1'b1;
    @(negedge clk);
    start = 1'b0; reg_mask = '0; sp_in = '0;
    cyc = 1;
    while (!done && cyc < 400) begin
      if (poke && cyc == 3) begin
        start = 1'b1; reg_mask = 16'hFFFF; sp_in = 32'h0000_0001;
      end else begin
        start = 1'b0; reg_mask = '0; sp_in = '0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done, "R9 completion reached", 32'(done), 32'd1);
    chk(cyc == exp_cyc, "R9 cycles to done", 32'(cyc), 32'(exp_cyc));
    chk(err == exp_err, "R7/R8 error flag", 32'(err), 32'(exp_err));
    chk(branch == exp_br, "R5 branch flag", 32'(branch), 32'(exp_br));
    chk(nreq == reads, "R7/R9 read count", 32'(nreq), 32'(reads));
    chk(nwr == writes, "R2/R7 write count", 32'(nwr), 32'(writes));
    chk(nsp == (aligned ? 1 : 0), "R3/R8 SP write count", 32'(nsp), 32'(aligned ? 1 : 0));
    @(negedge clk);
    chk(!done, "R10 done single cycle", 32'(done), 32'd0);
    chk(nwr == writes, "R7 no write after end", 32'(nwr), 32'(writes));
    active = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R10 start ignored while busy", 32'(busy | done), 32'd0);
    end
  endtask

  // mask, sp, latency, failing read ordinal (0 = none)
  localparam int NV = 8;
  localparam logic [56:0] VEC [NV] = '{
    {16'h0001, 32'h0000_1000, 4'd0, 5'd0},
    {16'h8001, 32'h2000_0040, 4'd1, 5'd0},
    {16'hFFFF, 32'hFFFF_FFF0, 4'd0, 5'd0},
    {16'h4A52, 32'h0000_8004, 4'd2, 5'd0},
    {16'h00F0, 32'h0000_3000, 4'd0, 5'd2},
    {16'h0000, 32'h0000_4000, 4'd0, 5'd0},
    {16'h0003, 32'h0000_1002, 4'd0, 5'd0},
    {16'h8000, 32'h0000_0100, 4'd3, 5'd1}
  };

  // ---------------------------------------------------------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // ---------------------------------------------------------------- main
  initial begin
    repeat (3) @(negedge clk);
    // R10: quiet outputs after reset
    chk(!busy && !done && !mem_req && !sp_we && !rf_we && !pc_we, "R10 reset state",
        {26'd0, busy, done, mem_req, sp_we, rf_we, pc_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R10 idle after reset", 32'(busy), 32'd0);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][56:41], VEC[v][40:9], int'(VEC[v][8:5]), int'(VEC[v][4:0]), 1'b0);
    end

    // R11: empty list, SP rewritten unchanged, no reads
    run(16'h0000, 32'h0000_0800, 0, 0, 1'b0);
    // R4: wrap of the pointer itself with PC load at the top
    run(16'hC000, 32'hFFFF_FFFC, 1, 0, 1'b0);
    // R10: start pulsed in the middle of a sequence is ignored
    run(16'h0006, 32'h0000_5000, 2, 0, 1'b1);
    // R7: failure on the last read of a longer list
    run(16'h0F0F, 32'h0000_6000, 1, 8, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule